// File: doc/BRIEF.md
# Strap-Configured Audio Master Clock Generator

This block produces the frame clock and the serial bit clock for a stereo audio converter acting as clock master. Both clocks are divided from the incoming master clock, which also clocks the block. For a fixed window after reset the two clock pads act as inputs. Their levels are sampled as configuration straps. One strap picks the speed mode and the other picks the ratio family between master clock and frame clock. During the same window a rate detector measures the master clock against a slow reference tick and picks the low or high member of that family.

When the window closes, the straps and the rate choice are frozen. Both output enables rise together, and the block drives a bit clock that runs at 64 times the frame clock. The frame clock changes level every 32 bit clocks. It always changes on a falling bit-clock edge, so a receiver can latch samples on the rising edge.

Top module: `audio_clk_master`

## Requirements
- R1: While reset is high, and until the power-up window ends, `lrck_oe` and `sclk_oe` are 0 and `lrck_o` and `sclk_o` are 0.
- R2: The window lasts `PWRUP_CYCLES` master clock cycles after reset is released. Both enables are 0 after the first `PWRUP_CYCLES`-1 rising edges and are 1 after edge `PWRUP_CYCLES`.
- R3: The speed-mode strap `lr_pad_i` selects the mode. 0 gives single speed and 1 gives double speed, which halves every bit-clock divide.
- R4: The family strap `bit_pad_i` selects the family. 0 gives the 256x/512x family (bit-clock divide 4 or 8) and 1 gives the 384x/768x family (divide 6 or 12). These divides are for single speed.
- R5: The rate detector measures the interval, in master clock cycles, from one `ref_tick` pulse to the next. If the most recently completed interval is greater than `RATE_LIMIT`, the high ratio (the doubled divide) is chosen. If it is not, or if no interval has completed, the low ratio is chosen.
- R6: A tick on the last cycle of the window still completes an interval and counts. Ticks after the window have no effect on the divide.
- R7: The bit-clock period is exactly the selected divide D in master clock cycles, where D is one of 2, 3, 4, 6, 8 or 12. The bit clock is low for floor(D/2) cycles and high for the rest.
- R8: `lrck_o` starts low when the enables rise. It then spends 32 bit-clock periods in each level, and it changes level only in a cycle where `sclk_o` falls.
- R9: Changing the strap pads after the window leaves the divide unchanged.
- R10: Asserting reset during operation returns the block to the power-up state. The straps are then latched again at the end of the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle reference pulse, synchronous to mclk |
| lr_pad_i | input | 1 | Level seen on the frame-clock pad (speed strap) |
| bit_pad_i | input | 1 | Level seen on the bit-clock pad (family strap) |
| lrck_o | output | 1 | Frame clock output value |
| lrck_oe | output | 1 | Frame clock pad output enable |
| sclk_o | output | 1 | Bit clock output value |
| sclk_oe | output | 1 | Bit clock pad output enable |

## Verification
Two things can fall in the same master clock cycle.

The first is the end of the power-up window and a reference tick. The bench places a tick exactly on the last window cycle after a long interval and expects the doubled divide. It then moves the same tick one cycle later and expects the low divide, judged from the measured bit-clock period.

The second is a frame-clock level change and a bit-clock falling edge. On every sample across two frames, the bench checks that any change of `lrck_o` comes with `sclk_o` going from 1 to 0. This is done for each divide, the odd divides of 3 and 6 included.

// File: rtl/audio_clk_master.sv
module audio_clk_master #(
  parameter int PWRUP_CYCLES = 256,
  parameter int RATE_LIMIT   = 60,
  parameter int RATE_CNT_W   = 10
) (
  input  logic mclk,
  input  logic rst,
  input  logic ref_tick,
  input  logic lr_pad_i,
  input  logic bit_pad_i,
  output logic lrck_o,
  output logic lrck_oe,
  output logic sclk_o,
  output logic sclk_oe
);

  localparam int PW        = $clog2(PWRUP_CYCLES + 1);
  localparam int HALF_BITS = 32;
  localparam int BW        = $clog2(2 * HALF_BITS);
  localparam logic [RATE_CNT_W-1:0] CNT_MAX = '1;

  logic [PW-1:0]         pcnt;
  logic                  done;
  logic [1:0]            lr_sync, bit_sync;
  logic                  dsm, fam, hi_rate;
  logic [RATE_CNT_W-1:0] rcnt;
  logic                  seen_tick;
  logic [3:0]            phase;
  logic [BW-1:0]         bcnt;
  logic [3:0]            div;
  logic [3:0]            half;
  logic                  last_win;
  logic                  phase_wrap;

  assign last_win   = !done && (pcnt == PW'(PWRUP_CYCLES - 1));
  assign half       = div >> 1;
  assign phase_wrap = (phase == div - 4'd1);

  always_comb begin
    div = fam ? 4'd6 : 4'd4;
    if (hi_rate) div = div << 1;
    if (dsm)     div = div >> 1;
  end

  always_ff @(posedge mclk) begin
    if (rst) begin
      lr_sync  <= 2'b00;
      bit_sync <= 2'b00;
    end else begin
      lr_sync  <= {lr_sync[0], lr_pad_i};
      bit_sync <= {bit_sync[0], bit_pad_i};
    end
  end

  always_ff @(posedge mclk) begin
    if (rst) begin
      pcnt <= '0;
      done <= 1'b0;
      dsm  <= 1'b0;
      fam  <= 1'b0;
    end else if (!done) begin
      pcnt <= pcnt + 1'b1;
      if (last_win) begin
        done <= 1'b1;
        dsm  <= lr_sync[1];
        fam  <= bit_sync[1];
      end
    end
  end

  always_ff @(posedge mclk) begin
    if (rst) begin
      rcnt      <= '0;
      seen_tick <= 1'b0;
      hi_rate   <= 1'b0;
    end else if (!done) begin
      if (ref_tick) begin
        rcnt      <= RATE_CNT_W'(1);
        seen_tick <= 1'b1;
        if (seen_tick) hi_rate <= (rcnt > RATE_CNT_W'(RATE_LIMIT));
      end else if (rcnt != CNT_MAX) begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge mclk) begin
    if (rst || !done) begin
      phase <= '0;
      bcnt  <= '0;
    end else if (phase_wrap) begin
      phase <= '0;
      bcnt  <= bcnt + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign lrck_oe = done;
  assign sclk_oe = done;
  assign sclk_o  = done && (phase >= half);
  assign lrck_o  = done && bcnt[BW-1];

  p_quiet_in_reset_r1: assert property (@(posedge mclk)
    rst |=> (!lrck_oe && !sclk_oe && !lrck_o && !sclk_o));

  p_enable_at_window_end_r2: assert property (@(posedge mclk) disable iff (rst)
    $rose(sclk_oe) |-> ($past(pcnt) == PW'(PWRUP_CYCLES - 1)) && lrck_oe);

  p_lrck_on_sclk_fall_r8: assert property (@(posedge mclk) disable iff (rst)
    (lrck_oe && $past(lrck_oe) && (lrck_o != $past(lrck_o))) |-> $fell(sclk_o));

  p_frame_starts_low_r8: assert property (@(posedge mclk) disable iff (rst)
    $rose(lrck_oe) |-> !lrck_o);

  p_divide_frozen_r9: assert property (@(posedge mclk) disable iff (rst)
    (done && $past(done)) |-> $stable(div));

  p_phase_in_range_r7: assert property (@(posedge mclk) disable iff (rst)
    phase < div);

endmodule

// File: tb/audio_clk_master_test.sv
module audio_clk_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW_CYC     = 256;
  localparam int LIMIT      = 60;

  logic mclk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic lr_pad = 1'b0;
  logic bit_pad = 1'b0;
  logic lrck_o, lrck_oe, sclk_o, sclk_oe;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) mclk = ~mclk;

  audio_clk_master #(.PWRUP_CYCLES(PW_CYC), .RATE_LIMIT(LIMIT), .RATE_CNT_W(10)) uut (
    .mclk(mclk), .rst(rst), .ref_tick(ref_tick),
    .lr_pad_i(lr_pad), .bit_pad_i(bit_pad),
    .lrck_o(lrck_o), .lrck_oe(lrck_oe), .sclk_o(sclk_o), .sclk_oe(sclk_oe));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_up(input logic lr, input logic bp, input int gap, input int n, input int extra);
    lr_pad  = lr;
    bit_pad = bp;
    @(negedge mclk); rst = 1'b1;
    @(negedge mclk);
    @(negedge mclk);
    check("R1 enables in reset", {lrck_oe, sclk_oe}, 0);
    check("R1 outputs in reset", {lrck_o, sclk_o}, 0);
    rst = 1'b0;
    for (int k = 1; k <= PW_CYC + 3; k++) begin
      ref_tick = ((k >= 10) && gap > 0 && ((k - 10) % gap == 0) && ((k - 10) / gap < n)) || (k == extra);
      @(posedge mclk);
      @(negedge mclk);
      if (k == PW_CYC - 1) check("R2 enables low before window end", {lrck_oe, sclk_oe, sclk_o, lrck_o}, 0);
      if (k == PW_CYC) begin
        check("R2 enables high at window end", {lrck_oe, sclk_oe}, 3);
        check("R8 frame starts low", lrck_o, 0);
      end
    end
    ref_tick = 1'b0;
  endtask

  task automatic measure(input string req, input int exp_div);
    int period, high, lr_len, misalign, guard;
    logic ps, pl;
    guard = 0;
    ps = sclk_o;
    while (!(ps && !sclk_o) && guard < 100) begin
      ps = sclk_o; @(negedge mclk); guard++;
    end
    period = 0; high = 0;
    do begin
      if (sclk_o) high++;
      period++;
      ps = sclk_o;
      @(negedge mclk);
    end while (!(ps && !sclk_o) && period < 100);
    check({req, " R7 sclk period"}, period, exp_div);
    check({req, " R7 sclk high time"}, high, exp_div - exp_div / 2);
    misalign = 0; lr_len = 0;
    pl = lrck_o; ps = sclk_o;
    for (int i = 0; i < 2 * 64 * exp_div + 4; i++) begin
      @(negedge mclk);
      if (lrck_o != pl && !(ps && !sclk_o)) misalign++;
      if (lrck_o && !pl) lr_len = 0;
      if (lrck_o) lr_len++;
      if (!lrck_o && pl && lr_len > 0) begin
        check({req, " R8 lrck high span"}, lr_len, 32 * exp_div);
        lr_len = -1000000;
      end
      pl = lrck_o; ps = sclk_o;
    end
    check({req, " R8 lrck changes on sclk fall"}, misalign, 0);
  endtask

  task automatic t_default();
    power_up(1'b0, 1'b0, 0, 0, 0);
    measure("R3 R4 R5 default ssm 256x", 4);
  endtask

  task automatic t_dsm_low();
    power_up(1'b1, 1'b0, 30, 7, 0);
    measure("R3 dsm 128x", 2);
  endtask

  task automatic t_ssm_384_high();
    power_up(1'b0, 1'b1, 90, 3, 0);
    measure("R4 R5 ssm 768x", 12);
  endtask

  task automatic t_dsm_384();
    power_up(1'b1, 1'b1, 90, 3, 0);
    measure("R3 R5 dsm 384x", 6);
    power_up(1'b1, 1'b1, 30, 7, 0);
    measure("R3 R7 dsm 192x odd", 3);
  endtask

  task automatic t_tick_at_window_end();
    power_up(1'b0, 1'b0, 30, 7, PW_CYC);
    measure("R6 tick on last window cycle", 8);
    power_up(1'b0, 1'b0, 30, 7, PW_CYC + 1);
    measure("R6 tick after window", 4);
  endtask

  task automatic t_pads_then_reset();
    power_up(1'b0, 1'b1, 30, 7, 0);
    measure("R9 before pad change", 6);
    lr_pad = 1'b1; bit_pad = 1'b0;
    repeat (20) @(negedge mclk);
    measure("R9 pads ignored", 6);
    power_up(1'b1, 1'b0, 30, 7, 0);
    measure("R10 relatched after reset", 2);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_default();
    t_dsm_low();
    t_ssm_384_high();
    t_dsm_384();
    t_tick_at_window_end();
    t_pads_then_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule